// File: doc/BRIEF.md
# Latched Interrupt Status Aggregator

This block gathers interrupt events from a bank of status groups, each a fixed number of bits wide, and holds them in status registers that a processor can read. Every raw status input is compared against its value from the previous clock. A chosen subset of inputs reports both transitions. All other inputs report only the low-to-high change. Any reported event sets its status bit, and the bit stays set until the processor reads that register. The read returns the held value and clears the whole register in the same access.

Each status bit has an enable bit of its own. An enabled event also sets a hidden pending bit. The pending bits of a group are ORed into one bit of a master summary register, and any set master bit pulls the active-low interrupt output low. A disabled event is still held in the status register, but it stays out of the summary and off the interrupt line.

Software reaches the status, enable and summary registers through a simple address/strobe bus. Read data is combinational within the strobe cycle.

Top module: `irq_status_agg`

## Requirements
- R1: A reported event sets its status bit one clock after the input change, and the bit stays set until its status register is read.
- R2: A read strobe at address STAT_BASE+g returns group g's status in that cycle and clears all of group g's status and pending bits at the clock edge; other groups keep their bits.
- R3: A source whose bit is 0 in DUAL_EDGE_MASK (the default for every bit) reports an event only on a 0-to-1 change of its input; a 1-to-0 change sets nothing.
- R4: A source whose bit is 1 in DUAL_EDGE_MASK (bit g*GRP_W+b for group g, bit b) reports an event on both 0-to-1 and 1-to-0 changes.
- R5: The enable register of group g is read and written at EN_BASE+g, and it resets to zero.
- R6: An event on a source whose enable bit is 0 sets its status bit but sets no pending bit, no summary bit and does not assert irq_n.
- R7: An event on an enabled source sets bit g of the summary register (read at MIR_ADDR, bits above NUM_GRP read 0), and irq_n is low from the next cycle until every group with pending bits has been read.
- R8: An event arriving in the same cycle as a clearing read of its register is still held after the read.
- R9: Reads of addresses outside the status, enable and summary locations return zero, and writes to status, summary or unmapped addresses change nothing.
- R10: After reset all status, enable and summary bits are zero and irq_n is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock; raw inputs are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_stat | input | NUM_GRP*GRP_W | Live status of all sources, group g at bits g*GRP_W upward |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | GRP_W | Write data |
| bus_rdata | output | GRP_W | Read data, valid in the cycle bus_rd is high |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with eight groups of eight bits, a 12-bit address, and a DUAL_EDGE_MASK of 0xF000. This makes the upper half of group 1 dual-edge and leaves every other source on the default rising mode. One group can therefore show both detection variants side by side in a single read value. The default address map places the enable block and the summary register away from the status block, so the bench can also probe unmapped holes between them.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_EN   = 2'd2,
      SEL_MIR  = 2'd3
   } sel_kind_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
   import irq_agg_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int NUM_GRP   = 8,
   parameter int IDX_W     = 3,
   parameter int STAT_BASE = 'h004,
   parameter int EN_BASE   = 'h014,
   parameter int MIR_ADDR  = 'h010
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_kind_e         kind,
   output logic [IDX_W-1:0]  idx
);
   localparam logic [ADDR_W-1:0] STAT_LO = ADDR_W'(STAT_BASE);
   localparam logic [ADDR_W-1:0] EN_LO   = ADDR_W'(EN_BASE);
   localparam logic [ADDR_W-1:0] MIR_A   = ADDR_W'(MIR_ADDR);
   localparam logic [ADDR_W-1:0] SPAN    = ADDR_W'(NUM_GRP);

   logic [ADDR_W-1:0] stat_off;
   logic [ADDR_W-1:0] en_off;

   assign stat_off = addr - STAT_LO;
   assign en_off   = addr - EN_LO;

   always_comb begin
      kind = SEL_NONE;
      idx  = '0;
      if (stat_off < SPAN) begin
         kind = SEL_STAT;
         idx  = stat_off[IDX_W-1:0];
      end else if (en_off < SPAN) begin
         kind = SEL_EN;
         idx  = en_off[IDX_W-1:0];
      end else if (addr == MIR_A) begin
         kind = SEL_MIR;
      end
   end
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
   parameter int             W         = 8,
   parameter logic [W-1:0]   DUAL_MASK = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw,
   output logic [W-1:0] evt
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= raw;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (DUAL_MASK[i]) begin : g_dual
         assign evt[i] = raw[i] ^ prev_q[i];
      end else begin : g_rise
         assign evt[i] = raw[i] & ~prev_q[i];
      end
   end
endmodule

// File: rtl/irq_status_group.sv
module irq_status_group #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         clr,
   input  logic         en_wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] stat_q,
   output logic [W-1:0] en_q,
   output logic         pend_any
);
   logic [W-1:0] pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
         pend_q <= '0;
         en_q   <= '0;
      end else begin
         stat_q <= (clr ? '0 : stat_q) | evt;
         pend_q <= (clr ? '0 : pend_q) | (evt & en_q);
         if (en_wr) en_q <= wdata;
      end
   end

   assign pend_any = |pend_q;

   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && evt == '0) |=> (stat_q == '0 && !pend_any));

   assert_pend_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

   assert_summary_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt & en_q)) |=> pend_any);

   assert_no_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
   import irq_agg_pkg::*;
#(
   parameter int NUM_GRP   = 8,
   parameter int GRP_W     = 8,
   parameter int ADDR_W    = 12,
   parameter int STAT_BASE = 'h004,
   parameter int EN_BASE   = 'h014,
   parameter int MIR_ADDR  = 'h010,
   parameter logic [NUM_GRP*GRP_W-1:0] DUAL_EDGE_MASK = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_GRP*GRP_W-1:0] raw_stat,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_rd,
   input  logic                     bus_wr,
   input  logic [GRP_W-1:0]         bus_wdata,
   output logic [GRP_W-1:0]         bus_rdata,
   output logic                     irq_n
);
   localparam int IDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
   localparam int TOT_W = NUM_GRP * GRP_W;

   if (NUM_GRP < 1 || GRP_W < 1) begin : g_chk_size
      $error("irq_status_agg: NUM_GRP and GRP_W must be positive");
   end
   if (NUM_GRP > GRP_W) begin : g_chk_mir
      $error("irq_status_agg: summary register must fit in GRP_W bits");
   end
   if (EN_BASE + NUM_GRP > (1 << ADDR_W) || STAT_BASE + NUM_GRP > (1 << ADDR_W)) begin : g_chk_addr
      $error("irq_status_agg: address map exceeds ADDR_W");
   end
   if (!(STAT_BASE + NUM_GRP <= EN_BASE || EN_BASE + NUM_GRP <= STAT_BASE)) begin : g_chk_ovl
      $error("irq_status_agg: status and enable blocks overlap");
   end

   sel_kind_e        kind;
   logic [IDX_W-1:0] idx;
   logic [TOT_W-1:0] evt_all;
   logic [TOT_W-1:0] en_all;
   logic [GRP_W-1:0] stat_a [NUM_GRP];
   logic [GRP_W-1:0] en_a   [NUM_GRP];
   logic [NUM_GRP-1:0] mir;

   irq_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_GRP(NUM_GRP), .IDX_W(IDX_W),
      .STAT_BASE(STAT_BASE), .EN_BASE(EN_BASE), .MIR_ADDR(MIR_ADDR)
   ) dec_i (
      .addr(bus_addr), .kind(kind), .idx(idx)
   );

   irq_edge_detect #(
      .W(TOT_W), .DUAL_MASK(DUAL_EDGE_MASK)
   ) edge_i (
      .clk(clk), .rst_n(rst_n), .raw(raw_stat), .evt(evt_all)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic hit;
      assign hit = (idx == IDX_W'(g));

      irq_status_group #(.W(GRP_W)) grp_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt     (evt_all[g*GRP_W +: GRP_W]),
         .clr     (bus_rd && kind == SEL_STAT && hit),
         .en_wr   (bus_wr && kind == SEL_EN && hit),
         .wdata   (bus_wdata),
         .stat_q  (stat_a[g]),
         .en_q    (en_a[g]),
         .pend_any(mir[g])
      );
      assign en_all[g*GRP_W +: GRP_W] = en_a[g];
   end

   always_comb begin
      unique case (kind)
         SEL_STAT: bus_rdata = stat_a[idx];
         SEL_EN:   bus_rdata = en_a[idx];
         SEL_MIR:  bus_rdata = GRP_W'(mir);
         default:  bus_rdata = '0;
      endcase
   end

   assign irq_n = ~(|mir);

   assert_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_all & en_all)) |=> !irq_n);

   assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == SEL_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb_top;
   localparam int NG = 8;
   localparam int GW = 8;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NG*GW-1:0] raw = '0;
   logic [AW-1:0] addr = '0;
   logic          rd = 1'b0;
   logic          wr = 1'b0;
   logic [GW-1:0] wdata = '0;
   logic [GW-1:0] rdata;
   logic          irq_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_status_agg #(
      .NUM_GRP(NG), .GRP_W(GW), .ADDR_W(AW),
      .STAT_BASE('h004), .EN_BASE('h014), .MIR_ADDR('h010),
      .DUAL_EDGE_MASK(64'h0000_0000_0000_F000)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .raw_stat(raw), .bus_addr(addr),
      .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata),
      .irq_n(irq_n)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [GW-1:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #2 d = rdata;
      @(negedge clk);
      rd = 1'b0; addr = '0;
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [GW-1:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic t_reset();
      logic [GW-1:0] d;
      check("R10 irq_n after reset", 32'(irq_n), 32'd1);
      for (int g = 0; g < NG; g++) begin
         bus_read(AW'('h004 + g), d);
         check("R10 status zero", 32'(d), 32'h0);
      end
      bus_read(AW'('h014), d);
      check("R10 R5 enable zero", 32'(d), 32'h0);
      bus_read(AW'('h010), d);
      check("R10 summary zero", 32'(d), 32'h0);
   endtask

   task automatic t_rising();
      logic [GW-1:0] d;
      step(); raw[0] = 1'b1;
      step(); step(); step();
      bus_read(AW'('h004), d);
      check("R1 R3 rising latched", 32'(d), 32'h01);
      bus_read(AW'('h004), d);
      check("R2 cleared after read", 32'(d), 32'h00);
      step(); raw[0] = 1'b0;
      step(); step();
      bus_read(AW'('h004), d);
      check("R3 falling ignored", 32'(d), 32'h00);
      check("R6 disabled irq_n high", 32'(irq_n), 32'd1);
   endtask

   task automatic t_dual();
      logic [GW-1:0] d;
      step(); raw[8+4] = 1'b1; raw[8+0] = 1'b1;
      step(); step();
      bus_read(AW'('h005), d);
      check("R4 R3 rise on both kinds", 32'(d), 32'h11);
      step(); raw[8+4] = 1'b0; raw[8+0] = 1'b0;
      step(); step();
      bus_read(AW'('h005), d);
      check("R4 dual falling reported", 32'(d), 32'h10);
   endtask

   task automatic t_enable();
      logic [GW-1:0] d;
      bus_write(AW'('h016), 8'h04);
      bus_read(AW'('h016), d);
      check("R5 enable readback", 32'(d), 32'h04);
      step(); raw[16+3] = 1'b1;
      step();
      check("R6 disabled source no irq", 32'(irq_n), 32'd1);
      bus_read(AW'('h010), d);
      check("R6 disabled source no summary", 32'(d), 32'h00);
      bus_read(AW'('h006), d);
      check("R6 disabled still latched", 32'(d), 32'h08);
      step(); raw[16+2] = 1'b1;
      step();
      check("R7 irq_n low next cycle", 32'(irq_n), 32'd0);
      bus_read(AW'('h010), d);
      check("R7 summary bit 2", 32'(d), 32'h04);
      bus_read(AW'('h006), d);
      check("R7 status of enabled source", 32'(d), 32'h04);
      check("R2 R7 irq released after read", 32'(irq_n), 32'd1);
      raw[16+2] = 1'b0; raw[16+3] = 1'b0;
   endtask

   task automatic t_isolation();
      logic [GW-1:0] d;
      step(); raw[24+1] = 1'b1; raw[32+1] = 1'b1;
      step(); step();
      bus_read(AW'('h007), d);
      check("R2 group 3 read", 32'(d), 32'h02);
      bus_read(AW'('h008), d);
      check("R2 group 4 untouched", 32'(d), 32'h02);
      raw[24+1] = 1'b0; raw[32+1] = 1'b0;
   endtask

   task automatic t_same_cycle();
      logic [GW-1:0] d;
      step(); raw[40+5] = 1'b1;
      step(); step();
      @(negedge clk);
      raw[40+6] = 1'b1; addr = AW'('h009); rd = 1'b1;
      #2 d = rdata;
      @(negedge clk);
      rd = 1'b0; addr = '0;
      check("R8 read shows old value", 32'(d), 32'h20);
      bus_read(AW'('h009), d);
      check("R8 event during read kept", 32'(d), 32'h40);
   endtask

   task automatic t_undef();
      logic [GW-1:0] d;
      bus_read(AW'('h000), d);
      check("R9 unmapped low reads zero", 32'(d), 32'h0);
      bus_read(AW'('h030), d);
      check("R9 unmapped high reads zero", 32'(d), 32'h0);
      bus_write(AW'('h00A), 8'hFF);
      bus_read(AW'('h00A), d);
      check("R9 status write ignored", 32'(d), 32'h0);
      bus_write(AW'('h030), 8'hFF);
      bus_read(AW'('h017), d);
      check("R9 stray write leaves enable", 32'(d), 32'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_rising();
      t_dual();
      t_enable();
      t_isolation();
      t_same_cycle();
      t_undef();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule